// File: doc/BRIEF.md
# Field Repetition Mode Selector for 100 Hz Scan Conversion

This block picks, once per output frame, the field-repetition sequence used by a double-rate interlaced scan converter. Four output field slots follow each stored input pair (first field A, second field B). The chosen sequence says, for each slot, which stored field the memory reader shows and whether that field is raster-interpolated (starred).

The decision draws on three things. The first is a programmed static mode. The second is an adaptive-control code. The third is three detector flags: global motion, film cadence detected, and film phase. The result is resolved from the current inputs. It is taken into the effective-mode register only on the output vertical sync strobe, so a sequence never changes partway through a frame. Between strobes, the slot selector gives the two slots that belong to the input field now being shown.

Top module: `fieldseq_selector`

## Requirements
- R1: While `rst` is high, and after its release until the first `osync` strobe, `eff_mode` is 4'b0010 (AABB).
- R2: Static code 4'b0000 (ABAB) gives slots 0..3 = A, B, A, B, with no slot starred.
- R3: Static code 4'b0001 gives slots 0..3 = A, A*, B*, B. A star marks an interpolated slot.
- R4: Static code 4'b0010 (AABB) gives slots 0..3 = A, A, B, B, with no slot starred.
- R5: Static code 4'b0011 (motion-adaptive soft mix) gives slots 0..3 = A, B*, A*, B.
- R6: Static code 4'b1000 (BABA) gives slots 0..3 = B, A, B, A, with no slot starred.
- R7: Any other static code is resolved to AABB (4'b0010), so `eff_mode` only ever holds 0000, 0001, 0010, 0011 or 1000.
- R8: With adaptive code 3'b000, the resolved static mode is used and the motion and film flags have no effect.
- R9: With adaptive code 3'b001 (motion only), the static mode is used when `gmotion`=0, and AABB when `gmotion`=1.
- R10: With adaptive code 3'b100 (film only), `movie`=1 selects ABAB when `movie_phase`=0 and BABA when `movie_phase`=1. `movie`=0 selects the static mode.
- R11: With adaptive code 3'b101 (film and motion), `movie`=1 applies the R10 film choice whatever `gmotion` is. Otherwise the R9 rule applies.
- R12: Adaptive codes 3'b010, 3'b011, 3'b110 and 3'b111 behave as 3'b000.
- R13: `eff_mode` is loaded only on a clock edge where `osync`=1. It changes one cycle after that edge and holds on every other edge.
- R14: `slot_is_b[i]` and `slot_starred[i]` (i = 0, 1) describe frame slot 2*`in_field_b`+i, with 1 = field B or starred. They follow `in_field_b` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osync | input | 1 | Output vertical sync strobe, one cycle wide |
| in_field_b | input | 1 | Current input field is the second (B) field of the pair |
| static_code | input | 4 | Programmed static sequence code |
| adapt_code | input | 3 | Adaptive-control code |
| gmotion | input | 1 | Global motion flag |
| movie | input | 1 | Film cadence detected |
| movie_phase | input | 1 | Film phase, 1 = B-first ordering |
| eff_mode | output | 4 | Latched effective sequence code |
| slot_is_b | output | 2 | Per slot of the current field: 1 = show stored field B |
| slot_starred | output | 2 | Per slot of the current field: 1 = interpolated field |

## Verification
The in-line assertions check several properties on every cycle:
- the effective mode holds between strobes;
- it only ever takes a legal code;
- film detection in the combined adaptive mode overrides motion at the strobe;
- the non-interpolating sequences never raise a star;
- ABAB and BABA alternate letters inside a field.

Only the bench scenarios can show the full mapping. This covers the exact slot letters and stars of each sequence, the fallback of every undefined static code, the adaptive codes that act as static, and the one-cycle latency from strobe to output.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int unsigned CODE_W        = 4;
    localparam int unsigned ADAPT_W       = 3;
    localparam int unsigned FRAME_SLOTS   = 4;
    localparam int unsigned FIELD_SLOTS   = FRAME_SLOTS / 2;
    localparam int unsigned SLOT_IDX_W    = $clog2(FRAME_SLOTS);

    typedef enum logic [CODE_W-1:0] {
        SEQ_ABAB = 4'b0000,
        SEQ_ASSB = 4'b0001,
        SEQ_AABB = 4'b0010,
        SEQ_SOFT = 4'b0011,
        SEQ_BABA = 4'b1000
    } seq_e;

    localparam logic [ADAPT_W-1:0] ADP_STATIC = 3'b000;
    localparam logic [ADAPT_W-1:0] ADP_MOTION = 3'b001;
    localparam logic [ADAPT_W-1:0] ADP_FILM   = 3'b100;
    localparam logic [ADAPT_W-1:0] ADP_BOTH   = 3'b101;

    typedef struct packed {
        logic is_b;
        logic starred;
    } slot_t;

    typedef struct packed {
        logic gmotion;
        logic movie;
        logic phase;
    } detect_t;

    function automatic seq_e legalize(input logic [CODE_W-1:0] code);
        case (code)
            4'b0000: return SEQ_ABAB;
            4'b0001: return SEQ_ASSB;
            4'b0011: return SEQ_SOFT;
            4'b1000: return SEQ_BABA;
            default: return SEQ_AABB;
        endcase
    endfunction

    function automatic slot_t slot_lookup(input seq_e m, input logic [SLOT_IDX_W-1:0] k);
        slot_t s;
        s.starred = 1'b0;
        case (m)
            SEQ_ABAB: s.is_b = k[0];
            SEQ_BABA: s.is_b = ~k[0];
            SEQ_ASSB: begin
                s.is_b    = k[1];
                s.starred = k[1] ^ k[0];
            end
            SEQ_SOFT: begin
                s.is_b    = k[0];
                s.starred = k[1] ^ k[0];
            end
            default:  s.is_b = k[1];
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fsq_decide.sv
module fsq_decide
    import fsq_pkg::*;
(
    input  logic [CODE_W-1:0]  static_code,
    input  logic [ADAPT_W-1:0] adapt_code,
    input  detect_t            det,
    output seq_e               choice
);
    seq_e base;
    seq_e film;
    seq_e motion_pick;

    always_comb begin
        base        = legalize(static_code);
        film        = det.phase ? SEQ_BABA : SEQ_ABAB;
        motion_pick = det.gmotion ? SEQ_AABB : base;
        case (adapt_code)
            ADP_MOTION: choice = motion_pick;
            ADP_FILM:   choice = det.movie ? film : base;
            ADP_BOTH:   choice = det.movie ? film : motion_pick;
            default:    choice = base;
        endcase
    end
endmodule

// File: rtl/fsq_hold.sv
module fsq_hold
    import fsq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  seq_e next_mode,
    output seq_e cur_mode
);
    always_ff @(posedge clk) begin
        if (rst)       cur_mode <= SEQ_AABB;
        else if (load) cur_mode <= next_mode;
    end

    p_hold_between_sync_r13: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur_mode));

    p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
        cur_mode inside {SEQ_ABAB, SEQ_ASSB, SEQ_AABB, SEQ_SOFT, SEQ_BABA});
endmodule

// File: rtl/fsq_slots.sv
module fsq_slots
    import fsq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  seq_e                   mode,
    input  logic                   second_field,
    output logic [FIELD_SLOTS-1:0] is_b,
    output logic [FIELD_SLOTS-1:0] starred
);
    for (genvar i = 0; i < FIELD_SLOTS; i++) begin : g_slot
        logic [SLOT_IDX_W-1:0] idx;
        slot_t                 s;
        always_comb begin
            idx        = SLOT_IDX_W'(i) | {second_field, {(SLOT_IDX_W-1){1'b0}}};
            s          = slot_lookup(mode, idx);
            is_b[i]    = s.is_b;
            starred[i] = s.starred;
        end
    end

    p_no_star_plain_r4: assert property (@(posedge clk) disable iff (rst)
        (mode inside {SEQ_ABAB, SEQ_BABA, SEQ_AABB}) |-> (starred == '0));

    p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
        (mode inside {SEQ_ABAB, SEQ_BABA}) |-> (is_b[0] != is_b[1]));
endmodule

// File: rtl/fieldseq_selector.sv
module fieldseq_selector
    import fsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               osync,
    input  logic               in_field_b,
    input  logic [3:0]         static_code,
    input  logic [2:0]         adapt_code,
    input  logic               gmotion,
    input  logic               movie,
    input  logic               movie_phase,
    output logic [3:0]         eff_mode,
    output logic [1:0]         slot_is_b,
    output logic [1:0]         slot_starred
);
    detect_t det;
    seq_e    choice;
    seq_e    cur;

    assign det = '{gmotion: gmotion, movie: movie, phase: movie_phase};

    fsq_decide u_decide (
        .static_code (static_code),
        .adapt_code  (adapt_code),
        .det         (det),
        .choice      (choice)
    );

    fsq_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (osync),
        .next_mode (choice),
        .cur_mode  (cur)
    );

    fsq_slots u_slots (
        .clk          (clk),
        .rst          (rst),
        .mode         (cur),
        .second_field (in_field_b),
        .is_b         (slot_is_b),
        .starred      (slot_starred)
    );

    assign eff_mode = cur;

    p_film_over_motion_r11: assert property (@(posedge clk) disable iff (rst)
        (osync && adapt_code == ADP_BOTH && movie) |=>
            (eff_mode == ($past(movie_phase) ? 4'b1000 : 4'b0000)));

    p_motion_forces_r9: assert property (@(posedge clk) disable iff (rst)
        (osync && adapt_code == ADP_MOTION && gmotion) |=> (eff_mode == 4'b0010));
endmodule

// File: tb/fieldseq_selector_test.sv
`timescale 1ns/1ps
module fieldseq_selector_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osync = 1'b0, fb = 1'b0, gm = 1'b0, mv = 1'b0, ph = 1'b0;
    logic [3:0] sc = 4'd0;
    logic [2:0] ad = 3'd0;
    logic [3:0] eff_mode;
    logic [1:0] slot_is_b, slot_starred;

    int vectors = 0;
    int miscompares = 0;
    int ref_mode = 2;
    bit finished = 0;

    always #2 clk = ~clk;

    fieldseq_selector uut (
        .clk(clk), .rst(rst), .osync(osync), .in_field_b(fb),
        .static_code(sc), .adapt_code(ad), .gmotion(gm), .movie(mv),
        .movie_phase(ph), .eff_mode(eff_mode), .slot_is_b(slot_is_b),
        .slot_starred(slot_starred)
    );

    function automatic int static_of(int code);
        if (code == 0 || code == 1 || code == 3 || code == 8) return code;
        return 2;
    endfunction

    function automatic int resolve(int code, int adp, bit g, bit m, bit p);
        int film = p ? 8 : 0;
        int st = static_of(code);
        if (adp == 1) return g ? 2 : st;
        if (adp == 4) return m ? film : st;
        if (adp == 5) return m ? film : (g ? 2 : st);
        return st;
    endfunction

    function automatic string letters(int m);
        case (m)
            0: return "ABAB";
            1: return "AABB";
            3: return "ABAB";
            8: return "BABA";
            default: return "AABB";
        endcase
    endfunction

    function automatic string stars(int m);
        if (m == 1 || m == 3) return "-**-";
        return "----";
    endfunction

    task automatic step(input bit s, input bit f, input int code, input int adp,
                        input bit g, input bit m, input bit p, input string tag);
        string l, st;
        logic [1:0] exp_b, exp_s;
        sc = code[3:0]; ad = adp[2:0]; gm = g; mv = m; ph = p; osync = s; fb = f;
        @(posedge clk);
        if (rst) ref_mode = 2;
        else if (s) ref_mode = resolve(code, adp, g, m, p);
        @(negedge clk);
        osync = 1'b0;
        l  = letters(ref_mode);
        st = stars(ref_mode);
        for (int i = 0; i < 2; i++) begin
            exp_b[i] = (l[f*2+i] == "B");
            exp_s[i] = (st[f*2+i] == "*");
        end
        vectors++;
        if (eff_mode !== ref_mode[3:0] || slot_is_b !== exp_b || slot_starred !== exp_s) begin
            miscompares++;
            $display("FAIL %s: mode=%0d slots_b=%b stars=%b, expected mode=%0d slots_b=%b stars=%b",
                     tag, eff_mode, slot_is_b, slot_starred, ref_mode, exp_b, exp_s);
        end
    endtask

    task automatic both_fields(input int code, input int adp, input bit g,
                               input bit m, input bit p, input string tag);
        step(1'b1, 1'b0, code, adp, g, m, p, tag);
        step(1'b0, 1'b1, code, adp, g, m, p, tag);
    endtask

    initial begin
        step(0, 0, 5, 5, 1, 1, 1, "R1");
        step(1, 1, 0, 0, 0, 0, 0, "R1");
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 1, 8, 0, 0, 0, 0, "R1");

        both_fields(0, 0, 0, 0, 0, "R2");
        both_fields(1, 0, 0, 0, 0, "R3");
        both_fields(2, 0, 0, 0, 0, "R4");
        both_fields(3, 0, 0, 0, 0, "R5");
        both_fields(8, 0, 0, 0, 0, "R6");
        for (int c = 0; c < 16; c++) begin
            if (static_of(c) == 2) both_fields(c, 0, 0, 0, 0, "R7");
        end

        both_fields(3, 0, 1, 1, 1, "R8");
        both_fields(0, 0, 1, 0, 0, "R8");

        both_fields(1, 1, 0, 1, 1, "R9");
        both_fields(1, 1, 1, 0, 0, "R9");
        both_fields(12, 1, 0, 0, 0, "R9");

        both_fields(3, 4, 1, 1, 0, "R10");
        both_fields(3, 4, 1, 1, 1, "R10");
        both_fields(1, 4, 1, 0, 1, "R10");

        both_fields(3, 5, 1, 1, 1, "R11");
        both_fields(3, 5, 1, 1, 0, "R11");
        both_fields(3, 5, 1, 0, 1, "R11");
        both_fields(3, 5, 0, 0, 1, "R11");

        for (int a = 2; a < 8; a++) begin
            if (a == 4 || a == 5) continue;
            both_fields(1, a, 1, 1, 1, "R12");
        end

        both_fields(3, 0, 0, 0, 0, "R13");
        step(0, 0, 0, 5, 1, 1, 1, "R13");
        step(0, 1, 8, 1, 1, 0, 0, "R13");
        step(1, 0, 8, 0, 0, 0, 0, "R13");

        step(0, 0, 1, 0, 0, 0, 0, "R14");
        both_fields(1, 0, 0, 0, 0, "R14");
        step(0, 0, 1, 0, 0, 0, 0, "R14");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule